// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-side control state of every hardware thread in a multithreaded front end. For each thread it keeps a state (running, squashing, blocked, waiting on an instruction-cache miss, and so on) together with the thread's current PC and the following sequential PC. The inputs are the events that move a thread between states: stall and release pulses from four downstream stages, redirect requests from the commit and decode stages, a flag that says the reorder buffer is still draining a squash, the start of an instruction-cache miss with its request tag, and cache fill completions tagged with a thread number and a request tag.

Each downstream stage raises a per-thread stall flag with a one-cycle block pulse and drops it with a one-cycle unblock pulse. A thread counts as stalled while any of its four flags is set. Redirects follow a fixed priority. A commit redirect beats everything else, and a decode redirect is ignored while the thread is already squashing. A fill that arrives for a request the thread is no longer waiting on is dropped. An aggregate flag reports whether the fetch stage has work in any active thread.

Top module: `fsc_fetch_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every thread is Running with PC equal to its `reset_pc` slice and next PC equal to that value plus `INST_BYTES` (default 4). State codes on `thread_state` are: 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 MissWait, 5 MissDone, 6 TrapWait, 7 QuiesceWait.
- R2: Stall flags are indexed by stage in the order 0 decode, 1 rename, 2 execute, 3 commit. Bit `t*4+s` of `block_pulse` sets flag s of thread t and the same bit of `unblock_pulse` clears it. When both arrive in the same cycle, the clear wins. If the updated flags hold any set bit and there is no squash, the thread enters Blocked on the next edge, except when it is in MissWait, where it stays.
- R3: A thread in Blocked or Squashing with no stall flag set after the update and no squash input returns to Running on the next edge.
- R4: A commit redirect (`cmt_squash[t]`) has the highest priority. On the next edge PC takes the target, next PC takes the target plus `INST_BYTES`, any outstanding miss is abandoned, and the state becomes Squashing.
- R5: With no commit redirect, `rob_busy[t]` puts or keeps the thread in Squashing and leaves its PC unchanged.
- R6: A decode redirect loads PC and next PC the way R4 does and enters Squashing, but only when the thread is not already in Squashing. Otherwise the PC is unchanged.
- R7: A thread in Running with no squash and no stall that sees `miss_start[t]` enters MissWait and records `miss_tag`. In any other state `miss_start` has no effect.
- R8: A fill (`fill_valid` with `fill_tid`, `fill_tag`) has no effect unless the named thread is in MissWait and `fill_tag` equals the recorded tag.
- R9: An accepted fill moves the thread to Blocked if it is stalled and to MissDone otherwise. MissDone returns to Running on the next edge.
- R10: `stage_active` is 1 exactly when some thread with its `active_mask` bit set is in Running, Squashing or MissDone.
- R11: `proto_err[t]` is 1 in the cycle after a cycle in which some stage's block and unblock pulses for thread t were both high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_pc | input | NT*PC_W | Per-thread PC loaded during reset |
| active_mask | input | NT | Threads that count toward stage_active |
| block_pulse | input | NT*4 | Stall set pulses, bit t*4+s |
| unblock_pulse | input | NT*4 | Stall clear pulses, bit t*4+s |
| cmt_squash | input | NT | Commit redirect request per thread |
| cmt_target | input | NT*PC_W | Commit redirect PC per thread |
| rob_busy | input | NT | Reorder buffer still squashing, per thread |
| dec_squash | input | NT | Decode redirect request per thread |
| dec_target | input | NT*PC_W | Decode redirect PC per thread |
| miss_start | input | NT | Instruction-cache miss issued, per thread |
| miss_tag | input | NT*TAG_W | Request tag of the issued miss |
| fill_valid | input | 1 | Cache fill completion strobe |
| fill_tid | input | TID_W | Thread number of the fill |
| fill_tag | input | TAG_W | Request tag of the fill |
| thread_state | output | NT*3 | Per-thread state code |
| thread_pc | output | NT*PC_W | Per-thread PC |
| thread_npc | output | NT*PC_W | Per-thread next PC |
| stage_active | output | 1 | Some active thread has fetch work |
| proto_err | output | NT | Same-cycle block and unblock seen, per thread |

## Verification
The hardest situation to reach is a fill that arrives while its thread is stalled in MissWait. This needs a miss to be issued from a clean Running state, a stall flag raised while the miss is pending, and then a fill with the matching tag, with no squash in between. A second hard case is the same fill arriving with a wrong tag or for the other thread. Directed sequences build these cases one step at a time on thread 0. A long run of sparse random pulses then reaches the mixed squash, stall and fill orderings on both threads, and a behavioural model in the bench follows every edge.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [2:0] {
        TS_RUN     = 3'd0,
        TS_IDLE    = 3'd1,
        TS_SQUASH  = 3'd2,
        TS_BLOCK   = 3'd3,
        TS_MISS    = 3'd4,
        TS_FILLED  = 3'd5,
        TS_TRAP    = 3'd6,
        TS_QUIESCE = 3'd7
    } tstate_e;

    localparam int NUM_STALL_SRC = 4;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic            stalled_o,
    output logic            err_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic            err;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d.flags = (st_q.flags | set_i) & ~clr_i;
        st_d.err   = |(set_i & clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // stall decision sees this cycle's pulses
    assign stalled_o = |st_d.flags;
    assign err_o     = st_q.err;
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int TAG_W      = 4,
    parameter int INST_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  reset_pc,
    input  logic             stalled,
    input  logic             cmt_sq,
    input  logic [PC_W-1:0]  cmt_tgt,
    input  logic             rob_sq,
    input  logic             dec_sq,
    input  logic [PC_W-1:0]  dec_tgt,
    input  logic             miss_go,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             fill_hit,
    input  logic [TAG_W-1:0] fill_tag,
    output tstate_e          state_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  npc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    typedef struct packed {
        tstate_e          st;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic [TAG_W-1:0] tag;
    } thr_s;

    thr_s th_d, th_q;
    logic fill_ok;

    always_comb begin
        th_d    = th_q;
        fill_ok = fill_hit && (th_q.st == TS_MISS) && (fill_tag == th_q.tag);
        if (cmt_sq) begin
            th_d.pc  = cmt_tgt;
            th_d.npc = cmt_tgt + STEP;
            th_d.st  = TS_SQUASH;
        end else if (rob_sq) begin
            th_d.st = TS_SQUASH;
        end else if (dec_sq && th_q.st != TS_SQUASH) begin
            th_d.pc  = dec_tgt;
            th_d.npc = dec_tgt + STEP;
            th_d.st  = TS_SQUASH;
        end else if (th_q.st != TS_MISS && stalled) begin
            th_d.st = TS_BLOCK;
        end else if (th_q.st == TS_BLOCK || th_q.st == TS_SQUASH) begin
            th_d.st = TS_RUN;
        end else begin
            case (th_q.st)
                TS_RUN: if (miss_go) begin
                    th_d.st  = TS_MISS;
                    th_d.tag = miss_tag;
                end
                TS_MISS:   if (fill_ok) th_d.st = stalled ? TS_BLOCK : TS_FILLED;
                TS_FILLED: th_d.st = TS_RUN;
                default:   th_d.st = th_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            th_q.st  <= TS_RUN;
            th_q.pc  <= reset_pc;
            th_q.npc <= reset_pc + STEP;
            th_q.tag <= '0;
        end else begin
            th_q <= th_d;
        end
    end

    assign state_o = th_q.st;
    assign pc_o    = th_q.pc;
    assign npc_o   = th_q.npc;
endmodule

// File: rtl/fsc_fetch_ctrl.sv
module fsc_fetch_ctrl
    import fsc_pkg::*;
#(
    parameter int NT         = 2,
    parameter int PC_W       = 32,
    parameter int TAG_W      = 4,
    parameter int INST_BYTES = 4,
    localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1,
    localparam int NS        = NUM_STALL_SRC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT*PC_W-1:0]  reset_pc,
    input  logic [NT-1:0]       active_mask,
    input  logic [NT*NS-1:0]    block_pulse,
    input  logic [NT*NS-1:0]    unblock_pulse,
    input  logic [NT-1:0]       cmt_squash,
    input  logic [NT*PC_W-1:0]  cmt_target,
    input  logic [NT-1:0]       rob_busy,
    input  logic [NT-1:0]       dec_squash,
    input  logic [NT*PC_W-1:0]  dec_target,
    input  logic [NT-1:0]       miss_start,
    input  logic [NT*TAG_W-1:0] miss_tag,
    input  logic                fill_valid,
    input  logic [TID_W-1:0]    fill_tid,
    input  logic [TAG_W-1:0]    fill_tag,
    output logic [NT*3-1:0]     thread_state,
    output logic [NT*PC_W-1:0]  thread_pc,
    output logic [NT*PC_W-1:0]  thread_npc,
    output logic                stage_active,
    output logic [NT-1:0]       proto_err
);
    logic [NT-1:0] has_work;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic    stalled;
        tstate_e st;

        fsc_stall_flags #(.NSRC(NS)) u_flags (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (block_pulse[t*NS +: NS]),
            .clr_i     (unblock_pulse[t*NS +: NS]),
            .stalled_o (stalled),
            .err_o     (proto_err[t])
        );

        fsc_thread_fsm #(
            .PC_W       (PC_W),
            .TAG_W      (TAG_W),
            .INST_BYTES (INST_BYTES)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .reset_pc (reset_pc[t*PC_W +: PC_W]),
            .stalled  (stalled),
            .cmt_sq   (cmt_squash[t]),
            .cmt_tgt  (cmt_target[t*PC_W +: PC_W]),
            .rob_sq   (rob_busy[t]),
            .dec_sq   (dec_squash[t]),
            .dec_tgt  (dec_target[t*PC_W +: PC_W]),
            .miss_go  (miss_start[t]),
            .miss_tag (miss_tag[t*TAG_W +: TAG_W]),
            .fill_hit (fill_valid && (32'(fill_tid) == t)),
            .fill_tag (fill_tag),
            .state_o  (st),
            .pc_o     (thread_pc[t*PC_W +: PC_W]),
            .npc_o    (thread_npc[t*PC_W +: PC_W])
        );

        assign thread_state[t*3 +: 3] = st;
        assign has_work[t] = active_mask[t] &&
                             (st == TS_RUN || st == TS_SQUASH || st == TS_FILLED);
    end

    assign stage_active = |has_work;
endmodule

// File: rtl/fsc_fetch_ctrl_chk.sv
module fsc_fetch_ctrl_chk #(
    parameter int NT         = 2,
    parameter int PC_W       = 32,
    parameter int TAG_W      = 4,
    parameter int INST_BYTES = 4,
    localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1,
    localparam int NS        = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NT*PC_W-1:0]  reset_pc,
    input logic [NT-1:0]       active_mask,
    input logic [NT*NS-1:0]    block_pulse,
    input logic [NT*NS-1:0]    unblock_pulse,
    input logic [NT-1:0]       cmt_squash,
    input logic [NT*PC_W-1:0]  cmt_target,
    input logic [NT-1:0]       rob_busy,
    input logic [NT-1:0]       dec_squash,
    input logic [NT*PC_W-1:0]  dec_target,
    input logic [NT-1:0]       miss_start,
    input logic [NT*TAG_W-1:0] miss_tag,
    input logic                fill_valid,
    input logic [TID_W-1:0]    fill_tid,
    input logic [TAG_W-1:0]    fill_tag,
    input logic [NT*3-1:0]     thread_state,
    input logic [NT*PC_W-1:0]  thread_pc,
    input logic [NT*PC_W-1:0]  thread_npc,
    input logic                stage_active,
    input logic [NT-1:0]       proto_err
);
    for (genvar t = 0; t < NT; t++) begin : g_chk
        a_r4_commit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
            cmt_squash[t] |=> (thread_state[t*3 +: 3] == 3'd2) &&
                              (thread_pc[t*PC_W +: PC_W] == $past(cmt_target[t*PC_W +: PC_W])));

        a_r6_squash_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmt_squash[t] && dec_squash[t] && thread_state[t*3 +: 3] == 3'd2)
            |=> $stable(thread_pc[t*PC_W +: PC_W]));

        a_r9_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[t*3 +: 3] != 3'd4) |=> (thread_state[t*3 +: 3] != 3'd5));

        a_r11_proto_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (|(block_pulse[t*NS +: NS] & unblock_pulse[t*NS +: NS])) |=> proto_err[t]);

        a_r10_running_active: assert property (@(posedge clk) disable iff (!rst_n)
            (active_mask[t] && thread_state[t*3 +: 3] == 3'd0) |-> stage_active);
    end
endmodule

bind fsc_fetch_ctrl fsc_fetch_ctrl_chk #(
    .NT(NT), .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES)
) u_chk (.*);

// File: tb/sim_fsc_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_fsc_fetch_ctrl;
    localparam int NT = 2, PC_W = 32, TAG_W = 4, IB = 4, NS = 4;

    logic clk = 0, rst_n = 0;
    logic [NT*PC_W-1:0]  reset_pc;
    logic [NT-1:0]       active_mask;
    logic [NT*NS-1:0]    block_pulse, unblock_pulse;
    logic [NT-1:0]       cmt_squash, rob_busy, dec_squash, miss_start;
    logic [NT*PC_W-1:0]  cmt_target, dec_target;
    logic [NT*TAG_W-1:0] miss_tag;
    logic                fill_valid;
    logic [0:0]          fill_tid;
    logic [TAG_W-1:0]    fill_tag;
    logic [NT*3-1:0]     thread_state;
    logic [NT*PC_W-1:0]  thread_pc, thread_npc;
    logic                stage_active;
    logic [NT-1:0]       proto_err;

    always #5 clk = ~clk;

    fsc_fetch_ctrl #(.NT(NT), .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(IB)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    int unsigned m_st[NT], m_pc[NT], m_npc[NT], m_tag[NT];
    bit m_flag[NT][NS];
    bit m_err[NT];

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        bit act_exp = 0;
        for (int t = 0; t < NT; t++) begin
            chk(req, $sformatf("state[%0d]", t), thread_state[t*3 +: 3], m_st[t]);
            chk(req, $sformatf("pc[%0d]", t), thread_pc[t*PC_W +: PC_W], m_pc[t]);
            chk(req, $sformatf("npc[%0d]", t), thread_npc[t*PC_W +: PC_W], m_npc[t]);
            chk("R11", $sformatf("err[%0d]", t), proto_err[t], m_err[t]);
            if (active_mask[t] && (m_st[t] == 0 || m_st[t] == 2 || m_st[t] == 5)) act_exp = 1;
        end
        chk("R10", "stage_active", stage_active, act_exp);
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_pc[t] = reset_pc[t*PC_W +: PC_W];
            m_npc[t] = m_pc[t] + IB; m_tag[t] = 0; m_err[t] = 0;
            for (int s = 0; s < NS; s++) m_flag[t][s] = 0;
        end
    endtask

    task automatic model_edge();
        for (int t = 0; t < NT; t++) begin
            bit stalled = 0, err = 0, hit;
            int unsigned cur = m_st[t];
            for (int s = 0; s < NS; s++) begin
                bit b = block_pulse[t*NS+s], u = unblock_pulse[t*NS+s];
                if (b) m_flag[t][s] = 1;
                if (u) m_flag[t][s] = 0;
                if (b && u) err = 1;
                if (m_flag[t][s]) stalled = 1;
            end
            m_err[t] = err;
            hit = fill_valid && fill_tid == t && cur == 4 && fill_tag == m_tag[t];
            if (cmt_squash[t]) begin
                m_pc[t] = cmt_target[t*PC_W +: PC_W]; m_npc[t] = m_pc[t] + IB; m_st[t] = 2;
            end else if (rob_busy[t]) m_st[t] = 2;
            else if (dec_squash[t] && cur != 2) begin
                m_pc[t] = dec_target[t*PC_W +: PC_W]; m_npc[t] = m_pc[t] + IB; m_st[t] = 2;
            end else if (cur != 4 && stalled) m_st[t] = 3;
            else if (cur == 3 || cur == 2) m_st[t] = 0;
            else if (cur == 0 && miss_start[t]) begin
                m_st[t] = 4; m_tag[t] = miss_tag[t*TAG_W +: TAG_W];
            end else if (cur == 4 && hit) m_st[t] = stalled ? 3 : 5;
            else if (cur == 5) m_st[t] = 0;
        end
    endtask

    task automatic quiet();
        block_pulse = 0; unblock_pulse = 0; cmt_squash = 0; rob_busy = 0;
        dec_squash = 0; miss_start = 0; fill_valid = 0;
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
        quiet();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        reset_pc = {32'h0000_0200, 32'h0000_0100};
        active_mask = 2'b11;
        cmt_target = 0; dec_target = 0; miss_tag = 0; fill_tid = 0; fill_tag = 0;
        quiet();
        model_reset();
        repeat (2) @(negedge clk);
        compare("R1");               // R1 during reset
        rst_n = 1;
        @(negedge clk);
        compare("R1");

        // R2 / R3: sticky flags, several sources
        block_pulse[0] = 1;                      step("R2");
        unblock_pulse[0] = 1;                    step("R3");
        block_pulse[1] = 1; block_pulse[2] = 1;  step("R2");
        unblock_pulse[1] = 1;                    step("R2");
        step("R2");
        unblock_pulse[2] = 1;                    step("R3");

        // R7 / R8 / R9: miss and fills
        miss_start[0] = 1; miss_tag[3:0] = 4'd5; step("R7");
        fill_valid = 1; fill_tag = 4'd6;         step("R8");
        fill_valid = 1; fill_tid = 1; fill_tag = 4'd5; step("R8");
        fill_tid = 0;
        fill_valid = 1; fill_tag = 4'd5;         step("R9");
        step("R9");
        miss_start[0] = 1; miss_tag[3:0] = 4'd3; step("R7");
        block_pulse[3] = 1;                      step("R2");
        fill_valid = 1; fill_tag = 4'd3;         step("R9");
        unblock_pulse[3] = 1;                    step("R3");

        // R4 / R5 / R6: redirect priority
        cmt_squash[0] = 1; cmt_target[31:0] = 32'h1000;
        dec_squash[0] = 1; dec_target[31:0] = 32'h2000; rob_busy[0] = 1;
        step("R4");
        rob_busy[0] = 1;                          step("R5");
        dec_squash[0] = 1; dec_target[31:0] = 32'h2000; step("R6");
        dec_squash[0] = 1; dec_target[31:0] = 32'h3000; step("R6");
        miss_start[0] = 1;                        step("R7");
        step("R3");
        rob_busy[0] = 1;                          step("R5");
        step("R3");

        // R11: same-cycle block and unblock
        block_pulse[5] = 1; unblock_pulse[5] = 1; step("R11");
        step("R11");

        // R10: mask selection
        block_pulse[0] = 1;                       step("R2");
        active_mask = 2'b01;                      step("R10");
        active_mask = 2'b11;                      step("R10");
        unblock_pulse[0] = 1;                     step("R3");

        // random mix on both threads (R2..R11 via model)
        for (int i = 0; i < 4000; i++) begin
            block_pulse   = NS'($urandom) & NS'($urandom) & NS'($urandom) ;
            block_pulse   = {$urandom} & {$urandom} & {$urandom};
            unblock_pulse = {$urandom} & {$urandom} & {$urandom};
            for (int t = 0; t < NT; t++) begin
                cmt_squash[t] = ($urandom % 20) == 0;
                rob_busy[t]   = ($urandom % 15) == 0;
                dec_squash[t] = ($urandom % 12) == 0;
                miss_start[t] = ($urandom % 4) == 0;
            end
            cmt_target = {$urandom, $urandom};
            dec_target = {$urandom, $urandom};
            miss_tag   = NT*TAG_W'($urandom % 4);
            fill_valid = ($urandom % 3) == 0;
            fill_tid   = 1'($urandom);
            fill_tag   = TAG_W'($urandom % 4);
            active_mask = 2'($urandom);
            step("R8 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule